// File: doc/BRIEF.md
# Frame-Paced Receive Endpoint Buffer

This block holds one received packet for a device-side endpoint until software drains it. Bytes arrive from a packet-level receive interface as single-cycle strobes. A separate end-of-packet strobe carries a good or bad flag. Accepted bytes go into a small FIFO, and a byte count tracks how many remain unread. A good end-of-packet latches a packet-complete flag. While that flag is set, the block refuses further traffic and raises a NAK indication, so the held data is never overwritten.

Software reaches the block through a four-address register port. Address 0 pops a FIFO byte. Address 1 returns the count. Address 2 holds the status flags, which clear on a write of one. Address 3 holds the interrupt masks. There are two interrupt sources.

- The per-packet source fires when a packet completes.
- The frame source fires on each start-of-frame marker.

Software can mask the per-packet source and instead service the endpoint once per frame. At that point the status flags tell it which of three cases applies: nothing arrived, a zero-length packet arrived, or a short packet of a known byte count is waiting.

Top module: `rx_frame_ep`

## Requirements
- R1: After reset the count is 0, all status flags are 0, `irq` is 0, the packet mask (control bit 0) is 0 and the frame mask (control bit 1) is 1.
- R2: Each accepted byte is appended to the FIFO and raises the count by one. A read of address 0 returns the oldest byte and lowers the count by one. Status bit 1 (receive-not-empty) is 1 exactly when the count is nonzero.
- R3: A good end-of-packet on an accepted packet sets status bit 0 (packet-complete). A packet with no bytes leaves packet-complete set and receive-not-empty clear.
- R4: A bad end-of-packet on an accepted packet empties the FIFO and leaves packet-complete clear.
- R5: A packet whose first strobe arrives while packet-complete is set is refused for its whole length, even if the flag is cleared partway through. `nak` is 1 while traffic is refused, its bytes are not stored, and its end-of-packet has no effect.
- R6: Writing address 2 with bit 0 set clears packet-complete and empties the FIFO. Writing it with bit 2 set clears the frame request. Zero bits leave the corresponding flags unchanged.
- R7: A `sof` pulse sets status bit 2 (frame request). A set in the same cycle as a clear wins.
- R8: `irq` equals (packet-complete AND NOT packet mask) OR (frame request AND NOT frame mask). A write to address 3 loads the packet mask from bit 0 and the frame mask from bit 1.
- R9: Bytes arriving while the FIFO already holds DEPTH bytes are dropped, and the count stays at DEPTH.
- R10: A read of address 1 returns the current byte count, zero-extended. Status bit 3 mirrors `nak`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W | Received byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_good | input | 1 | Packet passed its checks (valid with rx_eop) |
| sof | input | 1 | Start-of-frame marker pulse |
| nak | output | 1 | Incoming traffic is being refused |
| rd_en | input | 1 | Register read strobe (pops FIFO at address 0) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational from addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and DEPTH = 5. A FIFO depth that is not a power of two selects the explicit pointer-wrap variant. It also keeps the full sweep short: every packet length from 0 through DEPTH + 2 is sent with both good and bad endings. Because packets follow each other without a reset, the pointers wrap at many offsets, and the overflow lengths reach the saturation corner. The frame-paced service path is walked through its three outcomes. A refused packet is cleared mid-flight, and a clear is raced against a start-of-frame marker.

// File: rtl/rx_frame_ep_pkg.sv
package rx_frame_ep_pkg;

   typedef enum logic [1:0] {
      REG_DATA   = 2'd0,
      REG_COUNT  = 2'd1,
      REG_STATUS = 2'd2,
      REG_CTRL   = 2'd3
   } ep_reg_e;

   localparam int ST_DONE  = 0;
   localparam int ST_RNE   = 1;
   localparam int ST_FRAME = 2;
   localparam int ST_NAK   = 3;

   localparam int CT_PKT_MASK   = 0;
   localparam int CT_FRAME_MASK = 1;

endpackage

// File: rtl/rx_ep_fifo.sv
module rx_ep_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic              flush,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count
);

   localparam bit POW2 = ((1 << PTR_W) == DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_push, do_pop;

   if (DEPTH < 2) begin : g_depth_bad
      $error("rx_ep_fifo: DEPTH must be at least 2");
   end

   assign do_pop  = pop && (count != '0);
   assign do_push = push && (count != CNT_W'(DEPTH));

   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= push_data;
   end

   assign pop_data = mem[rd_ptr];

endmodule

// File: rtl/rx_ep_pkt_ctl.sv
module rx_ep_pkt_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_valid,
   input  logic rx_eop,
   input  logic rx_good,
   input  logic done_clr_req,
   output logic push,
   output logic flush,
   output logic pkt_done,
   output logic nak
);

   logic in_pkt, drop, accept, good_end, bad_end, done_clr;

   // A packet is accepted or refused as a whole, decided at its first strobe
   assign accept   = in_pkt ? !drop : !pkt_done;
   assign push     = rx_valid && accept;
   assign good_end = rx_eop && accept && rx_good;
   assign bad_end  = rx_eop && accept && !rx_good;
   assign done_clr = done_clr_req && pkt_done;
   assign flush    = bad_end || done_clr;
   assign nak      = !accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_done <= 1'b0;
         in_pkt   <= 1'b0;
         drop     <= 1'b0;
      end else begin
         if (good_end)      pkt_done <= 1'b1;
         else if (done_clr) pkt_done <= 1'b0;

         if (rx_eop) begin
            in_pkt <= 1'b0;
            drop   <= 1'b0;
         end else if (rx_valid && !in_pkt) begin
            in_pkt <= 1'b1;
            drop   <= pkt_done;
         end
      end
   end

endmodule

// File: rtl/rx_ep_irq.sv
module rx_ep_irq #(
   parameter bit FRAME_MASK_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof,
   input  logic frame_clr,
   input  logic ctrl_we,
   input  logic pkt_mask_d,
   input  logic frame_mask_d,
   input  logic pkt_done,
   output logic frame_req,
   output logic pkt_mask,
   output logic frame_mask,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_req  <= 1'b0;
         pkt_mask   <= 1'b0;
         frame_mask <= FRAME_MASK_RST;
      end else begin
         frame_req <= sof || (frame_req && !frame_clr);
         if (ctrl_we) begin
            pkt_mask   <= pkt_mask_d;
            frame_mask <= frame_mask_d;
         end
      end
   end

   assign irq = (pkt_done && !pkt_mask) || (frame_req && !frame_mask);

endmodule

// File: rtl/rx_frame_ep.sv
module rx_frame_ep
   import rx_frame_ep_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_eop,
   input  logic              rx_good,
   input  logic              sof,
   output logic              nak,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   if (DATA_W < 8) begin : g_width_bad
      $error("rx_frame_ep: DATA_W must be at least 8");
   end
   if (CNT_W > DATA_W) begin : g_cnt_bad
      $error("rx_frame_ep: count does not fit the read port");
   end

   logic              push, flush, pop, pkt_done, frame_req, pkt_mask, frame_mask;
   logic              st_we, ctrl_we;
   logic [DATA_W-1:0] pop_data;
   logic [CNT_W-1:0]  fifo_count;

   assign pop     = rd_en && (addr == REG_DATA);
   assign st_we   = wr_en && (addr == REG_STATUS);
   assign ctrl_we = wr_en && (addr == REG_CTRL);

   rx_ep_pkt_ctl u_pkt (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_eop       (rx_eop),
      .rx_good      (rx_good),
      .done_clr_req (st_we && wdata[ST_DONE]),
      .push         (push),
      .flush        (flush),
      .pkt_done     (pkt_done),
      .nak          (nak)
   );

   rx_ep_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (rx_data),
      .pop       (pop),
      .flush     (flush),
      .pop_data  (pop_data),
      .count     (fifo_count)
   );

   rx_ep_irq u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof          (sof),
      .frame_clr    (st_we && wdata[ST_FRAME]),
      .ctrl_we      (ctrl_we),
      .pkt_mask_d   (wdata[CT_PKT_MASK]),
      .frame_mask_d (wdata[CT_FRAME_MASK]),
      .pkt_done     (pkt_done),
      .frame_req    (frame_req),
      .pkt_mask     (pkt_mask),
      .frame_mask   (frame_mask),
      .irq          (irq)
   );

   always_comb begin
      rdata = '0;
      case (ep_reg_e'(addr))
         REG_DATA:   rdata = pop_data;
         REG_COUNT:  rdata = DATA_W'(fifo_count);
         REG_STATUS: begin
            rdata[ST_DONE]  = pkt_done;
            rdata[ST_RNE]   = (fifo_count != '0);
            rdata[ST_FRAME] = frame_req;
            rdata[ST_NAK]   = nak;
         end
         REG_CTRL: begin
            rdata[CT_PKT_MASK]   = pkt_mask;
            rdata[CT_FRAME_MASK] = frame_mask;
         end
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/rx_frame_ep_chk.sv
module rx_frame_ep_chk #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rx_eop,
   input logic             rx_good,
   input logic             sof,
   input logic             rd_en,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic             wbit0,
   input logic             nak,
   input logic             irq,
   input logic [CNT_W-1:0] count,
   input logic             pkt_done,
   input logic             frame_req,
   input logic             pkt_mask
);

   a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !(wr_en && addr == 2'd2 && wbit0)) |=> pkt_done);

   a_r7_sof_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> frame_req);

   a_r8_pkt_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !pkt_mask) |-> irq);

   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_done && !frame_req) |-> !irq);

   a_r5_refused_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (nak && rx_valid && !(rd_en && addr == 2'd0) && !wr_en) |=> count == $past(count));

   a_r4_bad_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eop && !rx_good && !nak) |=> (count == '0 && !pkt_done));

endmodule

bind rx_frame_ep rx_frame_ep_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_eop    (rx_eop),
   .rx_good   (rx_good),
   .sof       (sof),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .addr      (addr),
   .wbit0     (wdata[0]),
   .nak       (nak),
   .irq       (irq),
   .count     (fifo_count),
   .pkt_done  (pkt_done),
   .frame_req (frame_req),
   .pkt_mask  (pkt_mask)
);

// File: tb/rx_frame_ep_tb.sv
module rx_frame_ep_tb;

   localparam int DATA_W = 8;
   localparam int DEPTH  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_valid = 1'b0, rx_eop = 1'b0, rx_good = 1'b0, sof = 1'b0;
   logic [DATA_W-1:0] rx_data = '0;
   logic              rd_en = 1'b0, wr_en = 1'b0;
   logic [1:0]        addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              nak, irq;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   rx_frame_ep #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_eop(rx_eop), .rx_good(rx_good), .sof(sof), .nak(nak),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] v);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic send_bytes(input int n, input logic [DATA_W-1:0] base);
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1; rx_data = DATA_W'(base + i);
         @(negedge clk);
      end
      rx_valid = 1'b0;
   endtask

   task automatic send_eop(input logic g);
      rx_eop = 1'b1; rx_good = g;
      @(negedge clk); rx_eop = 1'b0; rx_good = 1'b0;
   endtask

   task automatic pulse_sof();
      sof = 1'b1;
      @(negedge clk); sof = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [DATA_W-1:0] v, base;
      int expc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd1, v); chk("R1 count", v, 0);
      rd(2'd2, v); chk("R1 status", v, 0);
      rd(2'd3, v); chk("R1 ctrl", v, 2);
      chk("R1 irq", irq, 0);

      // Sweep all lengths with both endings; pointers wrap across runs
      for (int len = 0; len <= DEPTH + 2; len++) begin
         for (int g = 0; g < 2; g++) begin
            base = DATA_W'(len * 17 + g * 5 + 3);
            send_bytes(len, base);
            send_eop(g[0]);
            expc = (g == 1) ? ((len > DEPTH) ? DEPTH : len) : 0;
            rd(2'd1, v); chk("R10 R9 R4 count", v, expc);
            rd(2'd2, v);
            chk("R3 R4 done", v[0], g);
            chk("R2 rne", v[1], (expc != 0) ? 1 : 0);
            chk("R10 nak bit", v[3], g);
            chk("R5 nak", nak, g);
            chk("R8 pkt irq", irq, g);
            if (g == 1 && len == 2) begin
               send_bytes(3, 8'hA0);
               send_eop(1'b1);
               rd(2'd1, v); chk("R5 refused count", v, expc);
            end
            for (int k = 0; k < expc; k++) begin
               rd(2'd0, v); chk("R2 data", v, DATA_W'(base + k));
            end
            rd(2'd1, v); chk("R2 drained", v, 0);
            wr(2'd2, 8'h01);
            rd(2'd2, v); chk("R6 cleared", v, 0);
         end
      end

      // R6 clear with unread bytes empties FIFO; zero write keeps flags
      send_bytes(3, 8'h40); send_eop(1'b1);
      rd(2'd0, v); chk("R2 first", v, 8'h40);
      wr(2'd2, 8'h00);
      rd(2'd2, v); chk("R6 zero write", v[0], 1);
      rd(2'd1, v); chk("R6 zero write count", v, 2);
      wr(2'd2, 8'h01);
      rd(2'd1, v); chk("R6 flush", v, 0);

      // R5 refusal persists after mid-packet clear
      send_eop(1'b1);
      send_bytes(2, 8'h50);
      chk("R5 nak mid", nak, 1);
      wr(2'd2, 8'h01);
      chk("R5 still refused", nak, 1);
      send_bytes(2, 8'h52); send_eop(1'b1);
      rd(2'd2, v); chk("R5 no done", v[0], 0);
      rd(2'd1, v); chk("R5 no bytes", v, 0);
      chk("R5 nak end", nak, 0);

      // Frame-paced service: packet interrupt masked, frame interrupt on
      wr(2'd3, 8'h01);
      rd(2'd3, v); chk("R8 ctrl", v, 1);
      pulse_sof();
      rd(2'd2, v); chk("R7 frame req", v[2], 1);
      chk("R3 no packet", v[1:0], 0);
      chk("R8 frame irq", irq, 1);
      wr(2'd2, 8'h04);
      chk("R8 irq low", irq, 0);
      send_eop(1'b1);
      chk("R8 masked pkt", irq, 0);
      pulse_sof();
      rd(2'd2, v); chk("R3 zero length", v[1:0], 1);
      wr(2'd2, 8'h05);
      send_bytes(3, 8'h60); send_eop(1'b1);
      pulse_sof();
      rd(2'd2, v); chk("R3 short", v[1:0], 3);
      rd(2'd1, v); chk("R10 short count", v, 3);
      wr(2'd2, 8'h05);
      rd(2'd2, v); chk("R6 both clear", v, 0);
      chk("R8 idle irq", irq, 0);

      // R7 set wins over clear in the same cycle
      pulse_sof();
      sof = 1'b1; addr = 2'd2; wdata = 8'h04; wr_en = 1'b1;
      @(negedge clk); sof = 1'b0; wr_en = 1'b0;
      rd(2'd2, v); chk("R7 set wins", v[2], 1);
      wr(2'd2, 8'h04);
      rd(2'd2, v); chk("R7 cleared", v[2], 0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule